// File: doc/BRIEF.md
# Descriptor Ring Fetch Controller

This block steps through a circular list of fixed-size DMA descriptors in memory for a single channel. Each descriptor's first word carries an ownership flag. When the flag says the engine owns the descriptor, the block hands the descriptor's address and word to a downstream data mover over a valid/ready handshake. It then waits for the mover to report completion, writes the word back with the ownership flag cleared, and moves to the next slot. After the last slot it returns to the first.

Software controls progress through a tail register that holds an absolute descriptor address. The engine halts in a suspended state in two cases: its current address equals the tail, or the fetched descriptor is still owned by software. Both cases lead to the same suspended state. The only way out of it is a write to the tail register. That write makes the engine read the current descriptor again and re-test both stop conditions.

If the tail is set to an address the engine can never land on, tail stopping is switched off in practice, and the ownership flag alone stops the engine.

Top module: `desc_ring_fetch`

## Requirements
- R1: While reset is held and just after it, `status` reads 00 (idle), `stop_cause` reads 00, and `rd_req`, `wr_req` and `dsc_valid` are low.
- R2: A `start` pulse in idle captures `cfg_base` and `cfg_len`. The engine then reports `status` 01 (running) and issues its first read at exactly `cfg_base`. `rd_req` and `rd_addr` stay stable until `rd_ready`.
- R3: A descriptor whose word has bit 31 (the ownership flag) set to 1 is presented on `dsc_valid`, with its address on `dsc_addr` and its full word on `dsc_word`. All three are held stable until `dsc_ready`.
- R4: Only after `mv_done` does the engine issue exactly one write to that descriptor's address. The written word has bit 31 cleared and every other bit unchanged.
- R5: After each write-back the address grows by DESC_BYTES (default 16). After the slot at base + (len − 1) × DESC_BYTES, the next address is the base.
- R6: When the current address equals the tail register (an absolute byte address), the engine suspends without presenting that descriptor. `status` becomes 10 and `stop_cause` becomes 01.
- R7: When a fetched word has bit 31 equal to 0 and the tail does not match, the engine suspends without presenting it, and `stop_cause` becomes 10. This also applies to slots reached after a wrap.
- R8: With the tail set to an address outside the ring (for example base + len × DESC_BYTES), the engine runs through every owned slot and stops only on an ownership miss.
- R9: While suspended, the engine issues no read, write or descriptor handshake until a tail write. After a tail write it reads the current descriptor again and suspends again if a stop condition still holds.
- R10: A tail write clears `stop_cause` to 00 in the cycle after the write.
- R11: The tail test is equality only. A tail address below the current address does not stop the engine, which keeps running, wraps, and stops when the address becomes equal to the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that starts the engine from idle |
| cfg_base | input | AW | Byte address of ring slot 0 |
| cfg_len | input | LEN_W | Number of slots in the ring (0 treated as 1) |
| tail_wr | input | 1 | Write strobe for the tail register |
| tail_addr | input | AW | Absolute descriptor address written to the tail register |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Read address |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | DW | Read data word |
| wr_req | output | 1 | Write-back request |
| wr_addr | output | AW | Write-back address |
| wr_data | output | DW | Write-back word with the ownership flag cleared |
| wr_ready | input | 1 | Memory accepts the write |
| dsc_valid | output | 1 | Descriptor offered to the data mover |
| dsc_ready | input | 1 | Data mover accepts the descriptor |
| dsc_addr | output | AW | Address of the offered descriptor |
| dsc_word | output | DW | Word of the offered descriptor |
| mv_done | input | 1 | Data mover has finished the accepted descriptor |
| status | output | 2 | 00 idle, 01 running, 10 suspended |
| stop_cause | output | 2 | Sticky: 00 none, 01 tail match, 10 ownership miss |

## Verification
Some properties are checked by assertions on every cycle:
- The pointer always stays inside the ring and moves either one slot forward or back to the base.
- A presented descriptor is never the tail slot and always carries the ownership flag.
- Requests hold stable under back-pressure.
- Write-back words always have the flag cleared.
- Leaving suspension always follows a tail write.

Other behaviour only the directed scenarios can show:
- The order in which slots are served across a wrap.
- The memory contents after write-back.
- Which stop cause is recorded.
- Equality-only tail matching when the tail lies below the pointer.
- Re-evaluation after a tail write that leaves a software-owned slot in place.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RDWAIT,
      ST_CHECK,
      ST_ISSUE,
      ST_DONEWAIT,
      ST_WBACK,
      ST_ADVANCE,
      ST_SUSPEND
   } fetch_state_e;

   localparam logic [1:0] STAT_IDLE = 2'b00;
   localparam logic [1:0] STAT_RUN  = 2'b01;
   localparam logic [1:0] STAT_SUSP = 2'b10;

   localparam logic [1:0] CAUSE_NONE = 2'b00;
   localparam logic [1:0] CAUSE_TAIL = 2'b01;
   localparam logic [1:0] CAUSE_OWN  = 2'b10;

endpackage

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit #(
   parameter int AW         = 32,
   parameter int LEN_W      = 8,
   parameter int DESC_BYTES = 16,
   parameter bit REG_LAST   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             advance,
   input  logic [AW-1:0]    cfg_base,
   input  logic [LEN_W-1:0] cfg_len,
   output logic [AW-1:0]    cur_addr
);

   localparam int SH = $clog2(DESC_BYTES);
   localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

   generate
      if (DESC_BYTES < 4 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_size
         $error("DESC_BYTES must be a power of two of at least 4");
      end
      if (AW <= LEN_W + SH) begin : g_bad_aw
         $error("AW too narrow for LEN_W slots of DESC_BYTES");
      end
   endgenerate

   function automatic logic [LEN_W-1:0] last_index(input logic [LEN_W-1:0] n);
      return (n == '0) ? '0 : n - LEN_W'(1);
   endfunction

   logic [AW-1:0] base_q;
   logic [AW-1:0] cur_q;
   logic [AW-1:0] last_addr;
   logic          loaded_q;

   generate
      if (REG_LAST) begin : g_reg_last
         logic [AW-1:0] last_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               last_q <= '0;
            end else if (load) begin
               last_q <= cfg_base + (AW'(last_index(cfg_len)) << SH);
            end
         end
         assign last_addr = last_q;
      end else begin : g_comb_last
         logic [LEN_W-1:0] len_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               len_q <= '0;
            end else if (load) begin
               len_q <= cfg_len;
            end
         end
         assign last_addr = base_q + (AW'(last_index(len_q)) << SH);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         cur_q    <= '0;
         loaded_q <= 1'b0;
      end else if (load) begin
         base_q   <= cfg_base;
         cur_q    <= cfg_base;
         loaded_q <= 1'b1;
      end else if (advance) begin
         cur_q <= (cur_q == last_addr) ? base_q : cur_q + STEP;
      end
   end

   assign cur_addr = cur_q;

   assert_ptr_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q |-> (cur_q >= base_q && cur_q <= last_addr &&
                    ((cur_q - base_q) & (STEP - AW'(1))) == '0))
      else $error("pointer left the ring");

   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded_q && $past(loaded_q) && $past(advance) && !$past(load))
      |-> (cur_q == base_q || cur_q == $past(cur_q) + STEP))
      else $error("pointer moved by an illegal amount");

endmodule

// File: rtl/ring_seq_fsm.sv
module ring_seq_fsm
   import ring_fetch_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         tail_wr,
   input  logic         tail_hit,
   input  logic         own_bit,
   input  logic         rd_ready,
   input  logic         rd_rvalid,
   input  logic         dsc_ready,
   input  logic         mv_done,
   input  logic         wr_ready,
   output fetch_state_e state,
   output logic         load,
   output logic         advance,
   output logic         capture,
   output logic [1:0]   status,
   output logic [1:0]   cause
);

   fetch_state_e state_q, state_d;
   logic [1:0]   cause_q;
   logic         stop_now;

   assign stop_now = tail_hit || !own_bit;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (start)     state_d = ST_FETCH;
         ST_FETCH:    if (rd_ready)  state_d = ST_RDWAIT;
         ST_RDWAIT:   if (rd_rvalid) state_d = ST_CHECK;
         ST_CHECK: begin
            if (!stop_now)    state_d = ST_ISSUE;
            else if (tail_wr) state_d = ST_FETCH;
            else              state_d = ST_SUSPEND;
         end
         ST_ISSUE:    if (dsc_ready) state_d = ST_DONEWAIT;
         ST_DONEWAIT: if (mv_done)   state_d = ST_WBACK;
         ST_WBACK:    if (wr_ready)  state_d = ST_ADVANCE;
         ST_ADVANCE:                 state_d = ST_FETCH;
         ST_SUSPEND:  if (tail_wr)   state_d = ST_FETCH;
         default:                    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cause_q <= CAUSE_NONE;
      end else begin
         state_q <= state_d;
         if (tail_wr) begin
            cause_q <= CAUSE_NONE;
         end else if (state_q == ST_CHECK && stop_now) begin
            cause_q <= tail_hit ? CAUSE_TAIL : CAUSE_OWN;
         end
      end
   end

   assign state   = state_q;
   assign load    = (state_q == ST_IDLE) && start;
   assign advance = (state_q == ST_ADVANCE);
   assign capture = (state_q == ST_RDWAIT) && rd_rvalid;
   assign cause   = cause_q;

   always_comb begin
      unique case (state_q)
         ST_IDLE:    status = STAT_IDLE;
         ST_SUSPEND: status = STAT_SUSP;
         default:    status = STAT_RUN;
      endcase
   end

   assert_issue_not_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ISSUE && $past(state_q) == ST_CHECK) |-> !$past(tail_hit))
      else $error("tail slot was offered to the mover");

   assert_issue_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ISSUE && $past(state_q) == ST_CHECK) |-> $past(own_bit))
      else $error("software-owned slot was offered to the mover");

   assert_wback_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WBACK && $past(state_q) == ST_DONEWAIT) |-> $past(mv_done))
      else $error("write-back without completion");

endmodule

// File: rtl/desc_ring_fetch.sv
module desc_ring_fetch
   import ring_fetch_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int LEN_W      = 8,
   parameter int DESC_BYTES = 16,
   parameter int OWN_BIT    = 31,
   parameter bit REG_LAST   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    cfg_base,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             tail_wr,
   input  logic [AW-1:0]    tail_addr,
   output logic             rd_req,
   output logic [AW-1:0]    rd_addr,
   input  logic             rd_ready,
   input  logic             rd_rvalid,
   input  logic [DW-1:0]    rd_rdata,
   output logic             wr_req,
   output logic [AW-1:0]    wr_addr,
   output logic [DW-1:0]    wr_data,
   input  logic             wr_ready,
   output logic             dsc_valid,
   input  logic             dsc_ready,
   output logic [AW-1:0]    dsc_addr,
   output logic [DW-1:0]    dsc_word,
   input  logic             mv_done,
   output logic [1:0]       status,
   output logic [1:0]       stop_cause
);

   localparam logic [DW-1:0] OWN_MASK = DW'(1) << OWN_BIT;

   generate
      if (OWN_BIT < 0 || OWN_BIT >= DW) begin : g_bad_own
         $error("OWN_BIT outside the descriptor word");
      end
   endgenerate

   fetch_state_e  state;
   logic          load;
   logic          advance;
   logic          capture;
   logic [AW-1:0] cur_addr;
   logic [AW-1:0] tail_q;
   logic [DW-1:0] word_q;
   logic          tail_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail_q <= '0;
      end else if (tail_wr) begin
         tail_q <= tail_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (capture) begin
         word_q <= rd_rdata;
      end
   end

   assign tail_hit = (cur_addr == tail_q);

   ring_ptr_unit #(
      .AW(AW), .LEN_W(LEN_W), .DESC_BYTES(DESC_BYTES), .REG_LAST(REG_LAST)
   ) ptr_i (
      .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
      .cfg_base(cfg_base), .cfg_len(cfg_len), .cur_addr(cur_addr)
   );

   ring_seq_fsm fsm_i (
      .clk(clk), .rst_n(rst_n), .start(start), .tail_wr(tail_wr),
      .tail_hit(tail_hit), .own_bit(word_q[OWN_BIT]),
      .rd_ready(rd_ready), .rd_rvalid(rd_rvalid), .dsc_ready(dsc_ready),
      .mv_done(mv_done), .wr_ready(wr_ready), .state(state), .load(load),
      .advance(advance), .capture(capture), .status(status), .cause(stop_cause)
   );

   assign rd_req    = (state == ST_FETCH);
   assign rd_addr   = cur_addr;
   assign dsc_valid = (state == ST_ISSUE);
   assign dsc_addr  = cur_addr;
   assign dsc_word  = word_q;
   assign wr_req    = (state == ST_WBACK);
   assign wr_addr   = cur_addr;
   assign wr_data   = word_q & ~OWN_MASK;

   assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      status != 2'b11)
      else $error("illegal status code");

   assert_one_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req, wr_req, dsc_valid}))
      else $error("more than one request at once");

   assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)))
      else $error("read request dropped or changed");

   assert_dsc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(dsc_addr) && $stable(dsc_word)))
      else $error("descriptor offer dropped or changed");

   assert_wb_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !wr_data[OWN_BIT])
      else $error("write-back keeps ownership flag");

   assert_resume_by_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status) == STAT_SUSP && status != STAT_SUSP) |-> $past(tail_wr))
      else $error("left suspension without tail write");

   assert_cause_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tail_wr) |-> (stop_cause == CAUSE_NONE))
      else $error("tail write did not clear stop cause");

endmodule

// File: tb/desc_ring_fetch_tb_top.sv
module desc_ring_fetch_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LEN_W = 8;
   localparam logic [AW-1:0] BASE = 32'h0000_1000;
   localparam int NSLOT = 4;
   localparam int WD_LIMIT = 100000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [LEN_W-1:0] cfg_len = LEN_W'(NSLOT);
   logic             tail_wr = 1'b0;
   logic [AW-1:0]    tail_addr = '0;
   logic             rd_req, wr_req, dsc_valid;
   logic [AW-1:0]    rd_addr, wr_addr, dsc_addr;
   logic [DW-1:0]    wr_data, dsc_word;
   logic             rd_ready = 1'b1;
   logic             rd_rvalid = 1'b0;
   logic [DW-1:0]    rd_rdata = '0;
   logic             wr_ready = 1'b1;
   logic             dsc_ready = 1'b0;
   logic             mv_done = 1'b0;
   logic [1:0]       status, stop_cause;

   // model state
   logic [DW-1:0] mem [NSLOT];
   logic          pend = 1'b0;
   int            pend_idx = 0;
   int            done_cnt = 0;
   logic          done_ok = 1'b0;
   int            early_wr = 0;
   int            wr_cnt = 0;
   int            rd_cnt = 0;
   int            iss_cnt = 0;
   logic [AW-1:0] iss_addr [64];
   logic [DW-1:0] iss_word [64];
   logic          mv_block = 1'b0;
   logic          sw_en = 1'b0;
   int            sw_idx = 0;
   logic [DW-1:0] sw_val = '0;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   desc_ring_fetch dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(BASE), .cfg_len(cfg_len),
      .tail_wr(tail_wr), .tail_addr(tail_addr),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_addr(dsc_addr),
      .dsc_word(dsc_word), .mv_done(mv_done),
      .status(status), .stop_cause(stop_cause)
   );

   function automatic int slot_of(input logic [AW-1:0] a);
      return int'((a - BASE) >> 4) % NSLOT;
   endfunction

   // memory and data mover models, all driven at the falling edge
   always @(negedge clk) begin
      cycles = cycles + 1;
      if (sw_en) mem[sw_idx] = sw_val;
      rd_rvalid = pend;
      rd_rdata  = mem[pend_idx];
      pend      = rst_n && rd_req && rd_ready;
      if (rst_n && rd_req && rd_ready) begin
         pend_idx = slot_of(rd_addr);
         rd_cnt   = rd_cnt + 1;
      end
      if (rst_n && wr_req && wr_ready) begin
         if (!done_ok || wr_addr != iss_addr[(iss_cnt + 63) % 64]) early_wr = early_wr + 1;
         mem[slot_of(wr_addr)] = wr_data;
         done_ok = 1'b0;
         wr_cnt  = wr_cnt + 1;
      end
      mv_done = (done_cnt == 1);
      if (mv_done) done_ok = 1'b1;
      if (done_cnt != 0) done_cnt = done_cnt - 1;
      dsc_ready = !mv_block;
      if (rst_n && dsc_valid && dsc_ready) begin
         iss_addr[iss_cnt % 64] = dsc_addr;
         iss_word[iss_cnt % 64] = dsc_word;
         iss_cnt  = iss_cnt + 1;
         done_cnt = 3;
      end
   end

   initial begin
      @(negedge clk);
      while (cycles < WD_LIMIT) @(negedge clk);
      $display("FAIL watchdog expired (actual %0d cycles, expected fewer)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
      $finish;
   end

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_slot(input int i, input logic [DW-1:0] v);
      @(posedge clk);
      sw_idx = i; sw_val = v; sw_en = 1'b1;
      @(posedge clk);
      sw_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; start = 1'b0; tail_wr = 1'b0; mv_block = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_tail(input logic [AW-1:0] a);
      @(negedge clk);
      tail_addr = a; tail_wr = 1'b1;
      @(negedge clk);
      tail_wr = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_susp(input string req);
      int n = 0;
      while (status != 2'b10 && n < 300) begin
         @(negedge clk);
         n++;
      end
      check(status == 2'b10, req, 32'(status), 32'h2);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(status == 2'b00 && stop_cause == 2'b00, "R1 status in reset", {28'h0, status, stop_cause}, 32'h0);
      check(!rd_req && !wr_req && !dsc_valid, "R1 requests in reset", {29'h0, rd_req, wr_req, dsc_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(status == 2'b00 && !rd_req, "R1 idle after reset", {30'h0, status}, 32'h0);
   endtask

   task automatic t_basic();
      int n0 = iss_cnt;
      int w0 = wr_cnt;
      int n;
      for (int i = 0; i < NSLOT; i++) load_slot(i, 32'h8000_0100 + i);
      write_tail(BASE + 32'(NSLOT * 16));
      mv_block = 1'b1;
      pulse_start();
      check(status == 2'b01, "R2 running after start", 32'(status), 32'h1);
      check(rd_req && rd_addr == BASE, "R2 first read at base", rd_addr, BASE);
      n = 0;
      while (!dsc_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
      for (int k = 0; k < 4; k++) begin
         check(dsc_valid && dsc_addr == BASE && dsc_word == 32'h8000_0100,
               "R3 offer held under back-pressure", dsc_addr, BASE);
         @(negedge clk);
      end
      mv_block = 1'b0;
      wait_susp("R8 suspends only on ownership");
      check(iss_cnt - n0 == NSLOT, "R8 all slots served", 32'(iss_cnt - n0), 32'(NSLOT));
      for (int i = 0; i < NSLOT; i++) begin
         check(iss_addr[(n0 + i) % 64] == BASE + 32'(16 * i), "R5 slot order", iss_addr[(n0 + i) % 64], BASE + 32'(16 * i));
         check(iss_word[(n0 + i) % 64] == 32'h8000_0100 + i, "R3 offered word", iss_word[(n0 + i) % 64], 32'h8000_0100 + i);
         check(mem[i] == 32'h0000_0100 + i, "R4 write-back clears flag only", mem[i], 32'h0000_0100 + i);
      end
      check(wr_cnt - w0 == NSLOT, "R4 one write per slot", 32'(wr_cnt - w0), 32'(NSLOT));
      check(early_wr == 0, "R4 no write before done", 32'(early_wr), 32'h0);
      check(stop_cause == 2'b10, "R7 ownership stop after wrap", 32'(stop_cause), 32'h2);
      n = rd_cnt;
      repeat (20) @(negedge clk);
      check(rd_cnt == n && status == 2'b10 && !wr_req && !dsc_valid, "R9 idle while suspended", 32'(rd_cnt - n), 32'h0);
   endtask

   task automatic t_tail();
      int n0;
      do_reset();
      for (int i = 0; i < NSLOT; i++) load_slot(i, 32'h8000_0200 + i);
      n0 = iss_cnt;
      write_tail(BASE + 32'h20);
      pulse_start();
      wait_susp("R6 suspends on tail match");
      check(iss_cnt - n0 == 2, "R6 tail slot not offered", 32'(iss_cnt - n0), 32'h2);
      check(stop_cause == 2'b01, "R6 cause tail", 32'(stop_cause), 32'h1);
      check(mem[2] == 32'h8000_0202, "R6 tail slot untouched", mem[2], 32'h8000_0202);
      write_tail(BASE);
      check(stop_cause == 2'b00, "R10 cause cleared", 32'(stop_cause), 32'h0);
      check(status == 2'b01, "R9 resumes on tail write", 32'(status), 32'h1);
      wait_susp("R11 stops on equality after wrap");
      check(iss_cnt - n0 == 4, "R11 lower tail does not stop", 32'(iss_cnt - n0), 32'h4);
      check(iss_addr[(n0 + 3) % 64] == BASE + 32'h30, "R11 last served slot", iss_addr[(n0 + 3) % 64], BASE + 32'h30);
      check(stop_cause == 2'b01, "R11 cause tail", 32'(stop_cause), 32'h1);
   endtask

   task automatic t_owner();
      int n0 = iss_cnt;
      int r0;
      load_slot(0, 32'h8000_0300);
      load_slot(1, 32'h0000_0301);
      write_tail(BASE + 32'h30);
      wait_susp("R7 suspends on owned slot");
      check(iss_cnt - n0 == 1, "R7 only slot 0 served", 32'(iss_cnt - n0), 32'h1);
      check(stop_cause == 2'b10, "R7 cause ownership, tail elsewhere", 32'(stop_cause), 32'h2);
      r0 = rd_cnt;
      write_tail(BASE + 32'h30);
      check(stop_cause == 2'b00, "R10 cause cleared again", 32'(stop_cause), 32'h0);
      wait_susp("R9 re-evaluates and re-suspends");
      check(rd_cnt - r0 == 1 && iss_cnt - n0 == 1, "R9 single re-read, no offer", 32'(rd_cnt - r0), 32'h1);
      check(stop_cause == 2'b10, "R9 cause ownership again", 32'(stop_cause), 32'h2);
      load_slot(1, 32'h8000_0301);
      load_slot(2, 32'h8000_0302);
      write_tail(BASE + 32'h30);
      wait_susp("R6 stops at tail after resume");
      check(iss_cnt - n0 == 3, "R9 slots 1 and 2 served", 32'(iss_cnt - n0), 32'h3);
      check(iss_addr[(n0 + 1) % 64] == BASE + 32'h10, "R9 resumed at same slot", iss_addr[(n0 + 1) % 64], BASE + 32'h10);
      check(stop_cause == 2'b01, "R6 cause tail", 32'(stop_cause), 32'h1);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_tail();
      t_owner();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule